// File: doc/BRIEF.md
# Pseudo-Random Memory Bus Tester

This engine exercises an external parallel memory through a simple synchronous port. Its goal is to expose broken, shorted or stuck data and address connections. After a start pulse it first walks a single set bit across the data bus at one fixed address. Each walking value is read back and verified before the next one is written. It then runs two pattern passes over the whole address space. The first pass uses a pseudo-random word sequence from a seeded LFSR. The second pass uses the bitwise complement of that sequence, so every line is driven both high and low.

Within each pass the whole range is written before any location is read back. An address-line fault therefore shows up as a later write overwriting an earlier one. The LFSR is restarted from the same seed at the start of each phase, so the read phase regenerates exactly the words that were written. Every miscompare is queued with its address, the expected word and the word actually returned. When the queue is full, extra miscompares only advance a saturating counter. At the end the engine raises a completion flag together with a pass/fail verdict.

Top module: `mem_bus_tester`

## Requirements
- R1: After reset, busy, done, pass, err_valid, mem_we and mem_re are all 0.
- R2: A start pulse while idle begins a run. Counting the accepting edge as edge 0, done rises after edge 8*3 + 2*(3*2^ADDR_W), which is 408 at the defaults. A start pulse while busy has no effect on the sequence or its timing.
- R3: The walking phase uses address WALK_ADDR (default 0). For bit b = 0 up to DATA_W-1 in ascending order, it writes the word 1<<b and then reads that address back. Each write is compared before the next write is issued.
- R4: The pattern word for the k-th address (k = 0, 1, ...) is the LFSR state after k steps from SEED (default 0x5A). The LFSR is a right-shifting Galois register: the next state is s>>1, XORed with 0xB8 when bit 0 of s is 1 (for DATA_W = 8). It is reseeded at the start of every write phase and every read phase.
- R5: In each pattern pass, all 2^ADDR_W addresses are written in ascending order before any address is read. The reads then also go in ascending order.
- R6: The second pass writes and expects the bitwise inverse of the first pass's words.
- R7: Each miscompare queues one record. Records are presented first in, first out on err_addr/err_exp/err_act while err_valid is 1. A 1 on err_pop removes the head entry.
- R8: The queue holds 16 records. A miscompare that arrives while the queue is full is dropped, and err_ovf (4 bits) is incremented, saturating at 15.
- R9: When done is 1, it stays 1 until the next accepted start. pass is 1 exactly when the run produced no miscompare at all. An accepted start clears done, the queue and err_ovf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (accepted only while idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has finished |
| pass | output | 1 | Last finished run saw no miscompare |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata | input | DATA_W | Memory read word |
| err_valid | output | 1 | Error queue not empty |
| err_pop | input | 1 | Remove the head error record |
| err_addr | output | ADDR_W | Address of the head record |
| err_exp | output | DATA_W | Expected word of the head record |
| err_act | output | DATA_W | Word actually read for the head record |
| err_ovf | output | 4 | Saturating count of dropped records |

## Verification
Several properties are checked on every cycle:
- each walking read follows a write to the same address;
- a pattern read is issued only after all 2^ADDR_W writes of its pass;
- the LFSR never reaches zero;
- the queue never exceeds its depth, and a pop on an empty queue leaves it unchanged;
- the overflow counter stays at its maximum once it gets there;
- done is never high while busy.

Other behaviour can only be shown by the directed scenarios against a fault-injecting memory model: the exact word sequence, the inversion of the second pass, the contents and order of the logged records, the cycle on which done rises, and the fact that a mid-run start is ignored.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WALK_WR,
        S_WALK_RD,
        S_WALK_CMP,
        S_PAT_WR,
        S_PAT_RD,
        S_PAT_CMP
    } seq_state_e;

    // Feedback mask for a right-shifting Galois LFSR of the given width.
    function automatic logic [63:0] lfsr_taps(input int width);
        case (width)
            8:       return 64'h0000_0000_0000_00B8;
            16:      return 64'h0000_0000_0000_B400;
            32:      return 64'h0000_0000_8020_0003;
            default: return (64'h1 << (width - 1)) | (64'h1 << (width - 2));
        endcase
    endfunction

endpackage

// File: rtl/mbt_lfsr.sv
module mbt_lfsr #(
    parameter int          DATA_W = 8,
    parameter logic [63:0] SEED   = 64'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [DATA_W-1:0] state
);
    import mbt_pkg::*;

    localparam logic [63:0]       TAPS_FULL = lfsr_taps(DATA_W);
    localparam logic [DATA_W-1:0] TAPS      = TAPS_FULL[DATA_W-1:0];
    localparam logic [DATA_W-1:0] SEED_W    = SEED[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state <= SEED_W;
        end else if (step) begin
            state <= (state >> 1) ^ (state[0] ? TAPS : '0);
        end
    end

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/mbt_err_fifo.sv
module mbt_err_fifo #(
    parameter int REC_W      = 22,
    parameter int FIFO_DEPTH = 16,
    parameter int OVF_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [REC_W-1:0] push_rec,
    input  logic             pop,
    output logic             valid,
    output logic [REC_W-1:0] head_rec,
    output logic [OVF_W-1:0] ovf
);
    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;
    localparam logic [PTR_W:0]   CNT_FULL = (PTR_W + 1)'(FIFO_DEPTH);

    logic [REC_W-1:0] store [FIFO_DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [PTR_W:0]   cnt;
    logic             full, do_push, do_pop;

    assign full     = (cnt == CNT_FULL);
    assign do_push  = push && !full;
    assign do_pop   = pop && (cnt != '0);
    assign valid    = (cnt != '0);
    assign head_rec = store[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr) store[wp] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
            if (push && full && ovf != OVF_MAX) ovf <= ovf + 1'b1;
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_FULL);

    // R8
    ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf == OVF_MAX && !clr) |=> ovf == OVF_MAX);

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt == '0 && !push && !clr) |=> cnt == '0);

endmodule

// File: rtl/mbt_seq.sv
module mbt_seq #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int WALK_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] lfsr_state,
    output logic              lfsr_load,
    output logic              lfsr_step,
    output logic              rec_push,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_exp,
    output logic [DATA_W-1:0] rec_act
);
    import mbt_pkg::*;

    localparam int                DEPTH  = 1 << ADDR_W;
    localparam int                BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(DEPTH - 1);
    localparam logic [BIT_W-1:0]  LASTB  = BIT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] WADDR  = ADDR_W'(WALK_ADDR);

    seq_state_e        state;
    logic [ADDR_W-1:0] addr;
    logic [BIT_W-1:0]  bit_idx;
    logic              inv, done_q, err_seen;
    logic              walking, cmp_en, mismatch;
    logic [DATA_W-1:0] walk_val, pat_val, exp_val;

    assign walking   = (state == S_WALK_WR) || (state == S_WALK_RD) || (state == S_WALK_CMP);
    assign walk_val  = DATA_W'(1) << bit_idx;
    assign pat_val   = lfsr_state ^ {DATA_W{inv}};
    assign exp_val   = walking ? walk_val : pat_val;

    assign mem_we    = (state == S_WALK_WR) || (state == S_PAT_WR);
    assign mem_re    = (state == S_WALK_RD) || (state == S_PAT_RD);
    assign mem_addr  = walking ? WADDR : addr;
    assign mem_wdata = exp_val;

    assign cmp_en    = (state == S_WALK_CMP) || (state == S_PAT_CMP);
    assign mismatch  = cmp_en && (mem_rdata != exp_val);
    assign rec_push  = mismatch;
    assign rec_addr  = mem_addr;
    assign rec_exp   = exp_val;
    assign rec_act   = mem_rdata;

    assign clr       = (state == S_IDLE) && start;
    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign pass      = done_q && !err_seen;

    assign lfsr_load = ((state == S_WALK_CMP) && bit_idx == LASTB)
                    || ((state == S_PAT_WR) && addr == LAST)
                    || ((state == S_PAT_CMP) && addr == LAST && !inv);
    assign lfsr_step = (state == S_PAT_WR) || (state == S_PAT_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            addr     <= '0;
            bit_idx  <= '0;
            inv      <= 1'b0;
            done_q   <= 1'b0;
            err_seen <= 1'b0;
        end else begin
            if (mismatch) err_seen <= 1'b1;
            unique case (state)
                S_IDLE: if (start) begin
                    state    <= S_WALK_WR;
                    bit_idx  <= '0;
                    inv      <= 1'b0;
                    done_q   <= 1'b0;
                    err_seen <= 1'b0;
                end
                S_WALK_WR: state <= S_WALK_RD;
                S_WALK_RD: state <= S_WALK_CMP;
                S_WALK_CMP: begin
                    if (bit_idx == LASTB) begin
                        state <= S_PAT_WR;
                        addr  <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        state   <= S_WALK_WR;
                    end
                end
                S_PAT_WR: begin
                    if (addr == LAST) begin
                        addr  <= '0;
                        state <= S_PAT_RD;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                S_PAT_RD: state <= S_PAT_CMP;
                S_PAT_CMP: begin
                    if (addr == LAST) begin
                        addr <= '0;
                        if (inv) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            inv   <= 1'b1;
                            state <= S_PAT_WR;
                        end
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= S_PAT_RD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Checker state: pattern writes issued since the current pass began.
    logic [ADDR_W:0] wr_cnt;
    always_ff @(posedge clk) begin
        if (rst) wr_cnt <= '0;
        else if (state == S_PAT_WR) wr_cnt <= (addr == '0) ? 1 : wr_cnt + 1'b1;
    end

    // R5
    write_all_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAT_RD) |-> wr_cnt == (ADDR_W + 1)'(DEPTH));

    // R3
    walk_read_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WALK_RD) |-> ($past(mem_we) && $past(mem_addr) == mem_addr));

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/mem_bus_tester.sv
module mem_bus_tester #(
    parameter int          ADDR_W     = 6,
    parameter int          DATA_W     = 8,
    parameter logic [63:0] SEED       = 64'h5A,
    parameter int          WALK_ADDR  = 0,
    parameter int          FIFO_DEPTH = 16,
    parameter int          OVF_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              err_valid,
    input  logic              err_pop,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_act,
    output logic [OVF_W-1:0]  err_ovf
);
    localparam int REC_W = ADDR_W + 2 * DATA_W;

    logic              clr, lfsr_load, lfsr_step, rec_push;
    logic [DATA_W-1:0] lfsr_state, rec_exp, rec_act;
    logic [ADDR_W-1:0] rec_addr;
    logic [REC_W-1:0]  head;

    mbt_lfsr #(.DATA_W(DATA_W), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .load(lfsr_load), .step(lfsr_step), .state(lfsr_state)
    );

    mbt_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WALK_ADDR(WALK_ADDR)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .pass(pass), .clr(clr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata),
        .lfsr_state(lfsr_state), .lfsr_load(lfsr_load), .lfsr_step(lfsr_step),
        .rec_push(rec_push), .rec_addr(rec_addr), .rec_exp(rec_exp), .rec_act(rec_act)
    );

    mbt_err_fifo #(.REC_W(REC_W), .FIFO_DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(clr),
        .push(rec_push), .push_rec({rec_addr, rec_exp, rec_act}),
        .pop(err_pop), .valid(err_valid), .head_rec(head), .ovf(err_ovf)
    );

    assign err_addr = head[REC_W-1 -: ADDR_W];
    assign err_exp  = head[2*DATA_W-1 -: DATA_W];
    assign err_act  = head[DATA_W-1:0];

endmodule

// File: tb/tb_mem_bus_tester.sv
module tb_mem_bus_tester;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NA = 1 << AW;
    localparam int DONE_CYC = 8 * 3 + 2 * 3 * NA;

    logic clk = 0, rst = 1, start = 0, err_pop = 0;
    logic busy, done, pass, mem_we, mem_re, err_valid;
    logic [AW-1:0] mem_addr, err_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_act;
    logic [3:0] err_ovf;

    int checks = 0, fails = 0;

    // fault knobs of the memory model
    logic [DW-1:0] stuck0 = '0;
    logic [AW-1:0] astuck = '0;
    logic          xor_en = 0;
    logic [AW-1:0] xor_addr = '0;

    logic [DW-1:0] tmem [NA];
    int            op_cnt = 0;
    logic          log_we   [600];
    logic [AW-1:0] log_addr [600];
    logic [DW-1:0] log_data [600];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_bus_tester dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .err_valid(err_valid), .err_pop(err_pop),
        .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act), .err_ovf(err_ovf)
    );

    function automatic logic [DW-1:0] rd_fault(logic [DW-1:0] v, logic [AW-1:0] a);
        return (v ^ ((xor_en && a == xor_addr) ? 8'h01 : 8'h00)) & ~stuck0;
    endfunction

    always @(posedge clk) begin
        if (mem_we) tmem[mem_addr & ~astuck] <= mem_wdata;
        if (mem_re) mem_rdata <= rd_fault(tmem[mem_addr & ~astuck], mem_addr);
        if ((mem_we || mem_re) && op_cnt < 600) begin
            log_we[op_cnt]   <= mem_we;
            log_addr[op_cnt] <= mem_addr;
            log_data[op_cnt] <= mem_wdata;
            op_cnt <= op_cnt + 1;
        end
    end

    function automatic logic [DW-1:0] pat(int k);
        logic [DW-1:0] s = 8'h5A;
        for (int i = 0; i < k; i++) s = s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected miscompare list from an independent model of the memory faults.
    int            e_n;
    logic [AW-1:0] e_a [200];
    logic [DW-1:0] e_e [200];
    logic [DW-1:0] e_x [200];

    task automatic build_expected();
        logic [DW-1:0] m [NA];
        logic [DW-1:0] r;
        e_n = 0;
        for (int a = 0; a < NA; a++) m[a] = '0;
        for (int b = 0; b < DW; b++) begin
            m[0 & ~astuck] = 8'(1 << b);
            r = rd_fault(m[0 & ~astuck], 0);
            if (r != 8'(1 << b)) begin
                e_a[e_n] = 0; e_e[e_n] = 8'(1 << b); e_x[e_n] = r; e_n++;
            end
        end
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < NA; a++) m[AW'(a) & ~astuck] = pat(a) ^ {DW{p[0]}};
            for (int a = 0; a < NA; a++) begin
                r = rd_fault(m[AW'(a) & ~astuck], AW'(a));
                if (r != (pat(a) ^ {DW{p[0]}})) begin
                    e_a[e_n] = AW'(a); e_e[e_n] = pat(a) ^ {DW{p[0]}}; e_x[e_n] = r; e_n++;
                end
            end
        end
    endtask

    task automatic run(input int start_again_at, output int cyc);
        op_cnt = 0;
        start = 1;
        @(posedge clk); #1 start = 0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            if (cyc == start_again_at) start = 1;
            @(posedge clk); #1;
            start = 0;
            cyc++;
        end
    endtask

    task automatic drain_and_check(input string req);
        int n = 0;
        int exp_q = (e_n > 16) ? 16 : e_n;
        int exp_o = (e_n > 31) ? 15 : ((e_n > 16) ? e_n - 16 : 0);
        chk(pass == (e_n == 0), "R9 pass flag", pass, e_n == 0);
        chk(err_ovf == 4'(exp_o), "R8 overflow count", err_ovf, exp_o);
        while (err_valid && n < 20) begin
            chk(err_addr == e_a[n] && err_exp == e_e[n] && err_act == e_x[n], req,
                {err_addr, err_exp, err_act}, {e_a[n], e_e[n], e_x[n]});
            err_pop = 1;
            @(posedge clk); #1 err_pop = 0;
            n++;
        end
        chk(n == exp_q, "R8 queued record count", n, exp_q);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !pass && !err_valid && !mem_we && !mem_re, "R1 reset state",
            {busy, done, pass, err_valid, mem_we, mem_re}, 0);
    endtask

    task automatic t_clean();
        int cyc, bad;
        stuck0 = '0; astuck = '0; xor_en = 0;
        run(-1, cyc);
        chk(cyc == DONE_CYC, "R2 done timing", cyc, DONE_CYC);
        chk(done && pass && !err_valid && err_ovf == 0, "R9 clean verdict",
            {done, pass, err_valid, err_ovf}, 6'b110000);
        chk(op_cnt == 2 * DW + 4 * NA, "R5 operation count", op_cnt, 2 * DW + 4 * NA);
        bad = 0;
        for (int b = 0; b < DW; b++) begin
            if (!(log_we[2*b] && log_addr[2*b] == 0 && log_data[2*b] == 8'(1 << b))) bad++;
            if (!(!log_we[2*b+1] && log_addr[2*b+1] == 0)) bad++;
        end
        chk(bad == 0, "R3 walking-ones sequence", bad, 0);
        for (int p = 0; p < 2; p++) begin
            int base = 2 * DW + p * 2 * NA;
            int bw = 0, bo = 0;
            for (int a = 0; a < NA; a++) begin
                if (!(log_we[base+a] && log_addr[base+a] == AW'(a)
                      && log_data[base+a] == (pat(a) ^ {DW{p[0]}}))) bw++;
                if (!(!log_we[base+NA+a] && log_addr[base+NA+a] == AW'(a))) bo++;
            end
            if (p == 0) chk(bw == 0, "R4 pattern words pass 1", bw, 0);
            else        chk(bw == 0, "R6 inverted words pass 2", bw, 0);
            chk(bo == 0, "R5 reads follow all writes", bo, 0);
        end
        chk(done == 1, "R9 done held", done, 1);
    endtask

    task automatic t_start_ignored();
        int cyc;
        run(100, cyc);
        chk(cyc == DONE_CYC, "R2 mid-run start ignored (timing)", cyc, DONE_CYC);
        chk(pass && op_cnt == 2 * DW + 4 * NA, "R2 mid-run start ignored (ops)", op_cnt,
            2 * DW + 4 * NA);
    endtask

    task automatic t_one_addr();
        int cyc;
        stuck0 = '0; astuck = '0; xor_en = 1; xor_addr = 6'd5;
        build_expected();
        run(-1, cyc);
        chk(e_n == 2, "R6 both passes catch the bad word", e_n, 2);
        drain_and_check("R7 record fields, single bad address");
        xor_en = 0;
    endtask

    task automatic t_stuck_bit();
        int cyc;
        stuck0 = 8'h80; astuck = '0; xor_en = 0;
        build_expected();
        run(-1, cyc);
        chk(err_valid && err_addr == 0 && err_exp == 8'h80 && err_act == 8'h00,
            "R3 walking bit 7 fails first", {err_exp, err_act}, 16'h8000);
        drain_and_check("R8 records with stuck data bit");
        stuck0 = '0;
    endtask

    task automatic t_addr_fault();
        int cyc;
        stuck0 = '0; astuck = 6'h04; xor_en = 0;
        build_expected();
        run(-1, cyc);
        chk(e_n > 0, "R5 aliasing exposed by write-all-first", e_n, 1);
        drain_and_check("R7 records with stuck address bit");
        astuck = '0;
    endtask

    task automatic t_restart();
        int cyc;
        stuck0 = 8'h01;
        run(-1, cyc);
        stuck0 = '0;
        run(-1, cyc);
        chk(pass && !err_valid && err_ovf == 0, "R9 start clears queue and counter",
            {pass, err_valid, err_ovf}, 6'b100000);
    endtask

    initial begin
        for (int a = 0; a < NA; a++) tmem[a] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_clean();
        t_start_ignored();
        t_one_addr();
        t_stuck_bit();
        t_addr_fault();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule